// File: doc/BRIEF.md
# Fixed-Point Escape-Time Fractal Pixel Engine

This block walks every pixel of a rectangular view of the complex plane and works out the escape-time count for each one. The default view is 1024 pixels across and 768 lines down. For each pixel it maps the column and row to a complex constant c. It then repeats z = z² + c, starting from z = 0, until the squared magnitude of z passes 4 or the iteration limit is reached. All arithmetic is signed fixed-point. There is no floating point and no divider.

A pulse on `start` latches four window bounds and an iteration limit. Results leave one pixel at a time through a valid/ready pair: the column, the row and the count. The next pixel is computed only after the current result is accepted. A one-cycle `frame_done` pulse follows the acceptance of the bottom-right pixel. Colouring, frame storage and display timing belong to neighbouring blocks.

Top module: `mandel_iter_top`

## Requirements
- R1: After reset, `out_valid` and `frame_done` are low, and they stay low until a `start` pulse arrives.
- R2: The constant for pixel (px, py) is cx = x_lo + px·sx and cy = y_lo + py·sy, each wrapped to DATA_W bits. Row 0 maps to y_lo. The step is s = ((hi − lo) · floor(2^FRAC_W / N)) >>> FRAC_W, formed at double width, where N is H_PIX for x and V_PIX for y. All values are two's complement with FRAC_W fractional bits.
- R3: Each iteration updates both parts from the same old z. The new real part is x² − y² + cx. The new imaginary part is 2xy + cy. Each product is formed at 2·DATA_W bits, shifted arithmetically right by FRAC_W and truncated to DATA_W bits.
- R4: A point escapes when x² + y², held at double width after rescaling, is strictly greater than 4.0. The reported count is the number of updates made before the first test that escapes. A point whose magnitude stays exactly 4.0, such as c = −2, never escapes.
- R5: A point that does not escape reports exactly the iteration limit. A limit of 0 gives a count of 0 for every pixel.
- R6: Results are emitted in raster order. The column runs from 0 to H_PIX−1 before the row advances, and rows run from 0 to V_PIX−1. Every reported coordinate lies inside the image.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x`, `out_y` and `out_count` hold their values.
- R8: Each accepted result is followed by the next pixel in order. No pixel is skipped and none is repeated.
- R9: `frame_done` is high for exactly one cycle, in the cycle after pixel (H_PIX−1, V_PIX−1) is accepted. `out_valid` is low in that cycle.
- R10: A `start` pulse while a frame is in progress is ignored. Changes to the window and limit inputs during a frame do not affect that frame's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a frame when the block is idle |
| win_x_lo | input | DATA_W | Left edge of the view (real part) |
| win_x_hi | input | DATA_W | Right edge of the view (real part) |
| win_y_lo | input | DATA_W | Bottom edge of the view (imaginary part), mapped to row 0 |
| win_y_hi | input | DATA_W | Top edge of the view (imaginary part) |
| iter_limit | input | ITER_W | Maximum number of iterations per pixel |
| out_valid | output | 1 | A pixel result is on offer |
| out_ready | input | 1 | The consumer accepts the result |
| out_x | output | clog2(H_PIX) | Column of the result |
| out_y | output | clog2(V_PIX) | Row of the result |
| out_count | output | ITER_W | Escape count of the result |
| frame_done | output | 1 | One-cycle pulse after the last pixel is accepted |

## Verification
The bench builds the block with an 8 × 6 image, a 32-bit word with 28 fractional bits and an 8-bit count. At this size every pixel of every frame can be compared with a reference model, and the last-pixel and done behaviour recurs in every frame. The width of 8 selects the shift form of the step unit and the height of 6 selects the reciprocal-multiply form, so one build covers both variants. Iteration limits of 0 up to 60 reach the non-escaping boundary at c = −2, the zero-limit case and random stalls on the consumer side.

// File: rtl/mandel_pkg.sv
`timescale 1ns/1ps
package mandel_pkg;

   // Frame walker phases
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // waiting for start
      ST_LOAD = 2'd1,   // hand c to the iteration core, clear z
      ST_RUN  = 2'd2,   // one z update per cycle
      ST_SHOW = 2'd3    // result offered on the output handshake
   } walk_state_e;

endpackage

// File: rtl/mandel_step.sv
`timescale 1ns/1ps
// Per-axis step size: span times a reciprocal of the pixel count.
// A power-of-two count reduces to an arithmetic shift with identical result.
module mandel_step #(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 28,
   parameter int COUNT  = 1024
) (
   input  logic signed [DATA_W-1:0] lo,
   input  logic signed [DATA_W-1:0] hi,
   output logic signed [DATA_W-1:0] step
);
   localparam int PW      = 2 * DATA_W;
   localparam int SHIFT   = $clog2(COUNT);
   localparam bit IS_POW2 = (COUNT == (1 << SHIFT));
   localparam logic signed [PW-1:0] RECIP = (PW'(1) << FRAC_W) / PW'(COUNT);

   logic signed [DATA_W-1:0] span;
   assign span = hi - lo;

   generate
      if (IS_POW2) begin : g_shift
         assign step = span >>> SHIFT;
      end else begin : g_recip
         logic signed [PW-1:0] prod;
         logic signed [PW-1:0] scaled;
         assign prod   = PW'(span) * RECIP;
         assign scaled = prod >>> FRAC_W;
         assign step   = scaled[DATA_W-1:0];
         wire unused_hi = ^scaled[PW-1:DATA_W];
      end
   endgenerate

endmodule

// File: rtl/mandel_coord.sv
`timescale 1ns/1ps
// Maps one pixel index to its plane coordinate: base + idx * step.
module mandel_coord #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 10
) (
   input  logic signed [DATA_W-1:0] base,
   input  logic signed [DATA_W-1:0] step,
   input  logic        [IDX_W-1:0]  idx,
   output logic signed [DATA_W-1:0] coord
);
   logic signed [DATA_W-1:0] idx_s;
   logic signed [DATA_W-1:0] offs;

   assign idx_s = $signed({{(DATA_W-IDX_W){1'b0}}, idx});
   assign offs  = idx_s * step;
   assign coord = base + offs;

endmodule

// File: rtl/mandel_core.sv
`timescale 1ns/1ps
// One z = z^2 + c update per cycle with a double-width escape test.
module mandel_core #(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 28,
   parameter int ITER_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     run,
   input  logic signed [DATA_W-1:0] c_re,
   input  logic signed [DATA_W-1:0] c_im,
   input  logic        [ITER_W-1:0] lim,
   output logic                     fin,
   output logic        [ITER_W-1:0] cnt
);
   localparam int PW = 2 * DATA_W;
   localparam logic signed [PW-1:0] ESCAPE = PW'(4) << FRAC_W;

   logic signed [DATA_W-1:0] zr_q, zi_q, cr_q, ci_q;
   logic        [ITER_W-1:0] cnt_q;

   logic signed [PW-1:0] rr, ii, ri;
   logic signed [PW-1:0] rr_s, ii_s, ri_s, ri2, mag;
   logic signed [DATA_W-1:0] zr_nx, zi_nx;
   logic escaped;

   // double-width products, rescaled by the fractional width
   assign rr   = PW'(zr_q) * PW'(zr_q);
   assign ii   = PW'(zi_q) * PW'(zi_q);
   assign ri   = PW'(zr_q) * PW'(zi_q);
   assign rr_s = rr >>> FRAC_W;
   assign ii_s = ii >>> FRAC_W;
   assign ri_s = ri >>> FRAC_W;
   assign ri2  = ri_s <<< 1;

   assign mag     = rr_s + ii_s;
   assign escaped = (mag > ESCAPE);
   assign fin     = (cnt_q == lim) || escaped;

   assign zr_nx = rr_s[DATA_W-1:0] - ii_s[DATA_W-1:0] + cr_q;
   assign zi_nx = ri2[DATA_W-1:0] + ci_q;

   wire unused_ri = ^ri2[PW-1:DATA_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zr_q  <= '0;
         zi_q  <= '0;
         cr_q  <= '0;
         ci_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         zr_q  <= '0;
         zi_q  <= '0;
         cr_q  <= c_re;
         ci_q  <= c_im;
         cnt_q <= '0;
      end else if (run && !fin) begin
         zr_q  <= zr_nx;
         zi_q  <= zi_nx;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/mandel_iter_top.sv
`timescale 1ns/1ps
module mandel_iter_top #(
   parameter int DATA_W = 32,
   parameter int FRAC_W = 28,
   parameter int H_PIX  = 1024,
   parameter int V_PIX  = 768,
   parameter int ITER_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic signed [DATA_W-1:0]      win_x_lo,
   input  logic signed [DATA_W-1:0]      win_x_hi,
   input  logic signed [DATA_W-1:0]      win_y_lo,
   input  logic signed [DATA_W-1:0]      win_y_hi,
   input  logic        [ITER_W-1:0]      iter_limit,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [$clog2(H_PIX)-1:0]      out_x,
   output logic [$clog2(V_PIX)-1:0]      out_y,
   output logic [ITER_W-1:0]             out_count,
   output logic                          frame_done
);
   import mandel_pkg::*;

   localparam int X_W = $clog2(H_PIX);
   localparam int Y_W = $clog2(V_PIX);
   localparam logic [X_W-1:0] X_LAST = X_W'(H_PIX - 1);
   localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_PIX - 1);

   // elaboration-time parameter checks
   generate
      if (DATA_W - FRAC_W < 4) begin : g_bad_fmt
         $error("format needs at least 4 integer bits including sign");
      end
      if (H_PIX < 2 || V_PIX < 2) begin : g_bad_size
         $error("image must be at least 2 x 2");
      end
      if (DATA_W <= X_W + 1 || DATA_W <= Y_W + 1) begin : g_bad_idx
         $error("word too narrow for pixel index");
      end
      if (ITER_W < 1) begin : g_bad_iter
         $error("iteration count needs at least one bit");
      end
   endgenerate

   walk_state_e state_q;
   logic [X_W-1:0] px_q;
   logic [Y_W-1:0] py_q;
   logic signed [DATA_W-1:0] xlo_q, ylo_q, sx_q, sy_q;
   logic [ITER_W-1:0] lim_q;
   logic done_q;

   logic signed [DATA_W-1:0] sx_in, sy_in, c_re, c_im;
   logic core_fin;
   logic [ITER_W-1:0] core_cnt;
   logic at_last;

   mandel_step #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .COUNT(H_PIX)) i_step_x (
      .lo(win_x_lo), .hi(win_x_hi), .step(sx_in));
   mandel_step #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .COUNT(V_PIX)) i_step_y (
      .lo(win_y_lo), .hi(win_y_hi), .step(sy_in));

   mandel_coord #(.DATA_W(DATA_W), .IDX_W(X_W)) i_coord_x (
      .base(xlo_q), .step(sx_q), .idx(px_q), .coord(c_re));
   mandel_coord #(.DATA_W(DATA_W), .IDX_W(Y_W)) i_coord_y (
      .base(ylo_q), .step(sy_q), .idx(py_q), .coord(c_im));

   mandel_core #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ITER_W(ITER_W)) i_core (
      .clk  (clk),
      .rst_n(rst_n),
      .load (state_q == ST_LOAD),
      .run  (state_q == ST_RUN),
      .c_re (c_re),
      .c_im (c_im),
      .lim  (lim_q),
      .fin  (core_fin),
      .cnt  (core_cnt)
   );

   assign at_last = (px_q == X_LAST) && (py_q == Y_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         px_q    <= '0;
         py_q    <= '0;
         xlo_q   <= '0;
         ylo_q   <= '0;
         sx_q    <= '0;
         sy_q    <= '0;
         lim_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  xlo_q   <= win_x_lo;
                  ylo_q   <= win_y_lo;
                  sx_q    <= sx_in;
                  sy_q    <= sy_in;
                  lim_q   <= iter_limit;
                  px_q    <= '0;
                  py_q    <= '0;
                  state_q <= ST_LOAD;
               end
            end
            ST_LOAD: state_q <= ST_RUN;
            ST_RUN: begin
               if (core_fin) state_q <= ST_SHOW;
            end
            ST_SHOW: begin
               if (out_ready) begin
                  if (at_last) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     if (px_q == X_LAST) begin
                        px_q <= '0;
                        py_q <= py_q + 1'b1;
                     end else begin
                        px_q <= px_q + 1'b1;
                     end
                     state_q <= ST_LOAD;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign out_valid  = (state_q == ST_SHOW);
   assign out_x      = px_q;
   assign out_y      = py_q;
   assign out_count  = core_cnt;
   assign frame_done = done_q;

endmodule

// File: rtl/mandel_iter_chk.sv
`timescale 1ns/1ps
module mandel_iter_chk #(
   parameter int H_PIX  = 1024,
   parameter int V_PIX  = 768,
   parameter int ITER_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     out_valid,
   input logic                     out_ready,
   input logic [$clog2(H_PIX)-1:0] out_x,
   input logic [$clog2(V_PIX)-1:0] out_y,
   input logic [ITER_W-1:0]        out_count,
   input logic                     frame_done,
   input logic [ITER_W-1:0]        lim
);
   localparam int X_W = $clog2(H_PIX);
   localparam int Y_W = $clog2(V_PIX);

   a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable({out_x, out_y, out_count})));

   a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count <= lim));

   a_r6_coord_in_image: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_x <= X_W'(H_PIX - 1)) && (out_y <= Y_W'(V_PIX - 1))));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(out_valid && out_ready &&
                           out_x == X_W'(H_PIX - 1) && out_y == Y_W'(V_PIX - 1)));

   a_r9_done_no_offer: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !out_valid);

endmodule

bind mandel_iter_top mandel_iter_chk #(
   .H_PIX (H_PIX),
   .V_PIX (V_PIX),
   .ITER_W(ITER_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_x     (out_x),
   .out_y     (out_y),
   .out_count (out_count),
   .frame_done(frame_done),
   .lim       (lim_q)
);

// File: tb/test_mandel_iter_top.sv
`timescale 1ns/1ps
module test_mandel_iter_top;
   localparam int W  = 32;
   localparam int F  = 28;
   localparam int H  = 8;
   localparam int V  = 6;
   localparam int IW = 8;
   localparam int XW = $clog2(H);
   localparam int YW = $clog2(V);
   localparam int ONE = 1 << F;
   localparam longint FOUR = 64'sd4 <<< F;
   localparam int FRAME_GUARD = 60000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic signed [W-1:0] win_x_lo = '0, win_x_hi = '0, win_y_lo = '0, win_y_hi = '0;
   logic [IW-1:0] iter_limit = '0;
   logic out_ready = 1'b0;
   logic out_valid, frame_done;
   logic [XW-1:0] out_x;
   logic [YW-1:0] out_y;
   logic [IW-1:0] out_count;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   mandel_iter_top #(.DATA_W(W), .FRAC_W(F), .H_PIX(H), .V_PIX(V), .ITER_W(IW))
   i_mandel_iter_top (
      .clk(clk), .rst_n(rst_n), .start(start),
      .win_x_lo(win_x_lo), .win_x_hi(win_x_hi),
      .win_y_lo(win_y_lo), .win_y_hi(win_y_hi),
      .iter_limit(iter_limit),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_x(out_x), .out_y(out_y), .out_count(out_count),
      .frame_done(frame_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint fmul(input int a, input int b);
      return (longint'(a) * longint'(b)) >>> F;
   endfunction

   // R2: step from span times floor(2^F / n), rescaled
   function automatic int step_of(input int lo, input int hi, input int n);
      longint recip = (64'sd1 <<< F) / n;
      int span = hi - lo;
      return int'((longint'(span) * recip) >>> F);
   endfunction

   // R3/R4/R5 reference count
   function automatic int ref_count(input int cx, input int cy, input int lim);
      int x = 0;
      int y = 0;
      int n = 0;
      while (n < lim) begin
         longint x2 = fmul(x, x);
         longint y2 = fmul(y, y);
         longint xy = fmul(x, y);
         int nx, ny;
         if (x2 + y2 > FOUR) break;
         nx = int'(x2) - int'(y2) + cx;
         ny = int'(xy <<< 1) + cy;
         x = nx;
         y = ny;
         n++;
      end
      return n;
   endfunction

   task automatic run_frame(input int xl, input int xh, input int yl, input int yh,
                            input int lim, input int stall, input bit poke, input string tag);
      int sx = step_of(xl, xh, H);
      int sy = step_of(yl, yh, V);
      int k = 0;
      int cyc = 0;
      bit hold = 1'b0;
      int hx = 0, hy = 0, hc = 0;
      @(negedge clk);
      win_x_lo = xl; win_x_hi = xh; win_y_lo = yl; win_y_hi = yh;
      iter_limit = IW'(lim);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (k < H * V && cyc < FRAME_GUARD) begin
         check(frame_done == 1'b0, "R9", {tag, " done early"}, frame_done, 0);
         if (hold) begin
            check(out_valid == 1'b1, "R7", {tag, " valid dropped in stall"}, out_valid, 1);
            check(out_x == XW'(hx) && out_y == YW'(hy) && out_count == IW'(hc), "R7",
                  {tag, " offer changed in stall"},
                  {out_x, out_y, out_count}, {XW'(hx), YW'(hy), IW'(hc)});
         end
         if (cyc == 20 && poke) begin
            // R10: restart attempt with a different window and limit mid-frame
            start = 1'b1;
            win_x_lo = -ONE; win_x_hi = ONE / 2; win_y_lo = -ONE / 4; win_y_hi = ONE;
            iter_limit = IW'(lim + 7);
         end else begin
            start = 1'b0;
         end
         if (out_valid) begin
            bit rdy = ($urandom_range(0, 99) >= stall);
            out_ready = rdy;
            if (rdy) begin
               int ex = k % H;
               int ey = k / H;
               int cx = xl + ex * sx;
               int cy = yl + ey * sy;
               int ec = ref_count(cx, cy, lim);
               check(out_x == XW'(ex) && out_y == YW'(ey), "R6", {tag, " raster order (R8)"},
                     {out_y, out_x}, {YW'(ey), XW'(ex)});
               check(out_count == IW'(ec), "R3", {tag, " count via R2 mapping"}, out_count, ec);
               k++;
               hold = 1'b0;
            end else begin
               hold = 1'b1;
               hx = out_x; hy = out_y; hc = out_count;
            end
         end else begin
            out_ready = ($urandom_range(0, 1) == 1);
            hold = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      out_ready = 1'b0;
      if (cyc >= FRAME_GUARD) begin
         check(1'b0, "R8", {tag, " watchdog expired"}, k, H * V);
      end else begin
         check(frame_done == 1'b1, "R9", {tag, " done after last pixel"}, frame_done, 1);
         check(out_valid == 1'b0, "R9", {tag, " no offer with done"}, out_valid, 0);
         @(negedge clk);
         check(frame_done == 1'b0, "R9", {tag, " done lasts one cycle"}, frame_done, 0);
         check(out_valid == 1'b0, "R8", {tag, " idle after frame"}, out_valid, 0);
      end
   endtask

   initial begin
      void'($urandom(32'd2718));
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
      check(frame_done == 1'b0, "R1", "done in reset", frame_done, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid before start", out_valid, 0);
      check(frame_done == 1'b0, "R1", "done before start", frame_done, 0);

      // main view with stalls and a mid-frame restart attempt (R7, R10)
      run_frame(-2 * ONE, ONE, -(ONE + ONE / 4), ONE + ONE / 4, 30, 30, 1'b1, "R10 frame A");

      // R4: pixel (0,0) sits on c = -2, magnitude stays 4.0 and hits the limit
      run_frame(-2 * ONE, ONE / 2, 0, ONE, 40, 0, 1'b0, "R4 frame B");
      check(ref_count(-2 * ONE, 0, 40) == 40, "R4", "model c=-2 reaches limit",
            ref_count(-2 * ONE, 0, 40), 40);

      // R5: zero limit gives zero everywhere
      run_frame(-2 * ONE, 2 * ONE - 1, -2 * ONE, 2 * ONE - 1, 0, 20, 1'b0, "R5 frame C");

      // random views within [-2, 2]
      for (int f = 0; f < 4; f++) begin
         int xl = -2 * ONE + int'($urandom_range(0, 2 * ONE));
         int yl = -2 * ONE + int'($urandom_range(0, 2 * ONE));
         int xs = int'($urandom_range(ONE / 4, 2 * ONE));
         int ys = int'($urandom_range(ONE / 4, 2 * ONE));
         int lm = int'($urandom_range(1, 60));
         int st = int'($urandom_range(0, 60));
         run_frame(xl, xl + xs, yl, yl + ys, lm, st, f[0], "R2 random frame");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule